// File: doc/BRIEF.md
# Bayer Color Gain Steering Controller

This block chooses, on every pixel clock, which of four per-color gain words applies to the pixel being read out of a color image sensor. Software supplies the four 9-bit gains packed two per 18-bit word. The block follows field and line boundaries from the sensor's active-low vertical and horizontal sync pulses. It produces a 2-bit gain index and the gain word that the index selects, so that a downstream gain stage can weight the two colors of each Bayer row correctly.

Three readout modes pair lines with color pairs in different ways. In progressive readout every field restarts on the first color pair and each line alternates between the pairs. In interlaced readout the pair is fixed for a whole field, and consecutive fields alternate between the two pairs. In three-field readout the field number cycles through three values; the field number picks the starting pair and each line alternates it. A one-shot next-field write overrides the field number that the next field start would otherwise pick. In off mode the first gain is applied to every pixel.

Top module: `color_steer_top`

## Requirements
- R1: The 2-bit `steer_mode` input selects the behaviour: 0 off, 1 progressive, 2 interlaced, 3 three-field.
- R2: `gain_word` is the gain that `gain_idx` selects: index 0 is `gain_pair01[8:0]`, 1 is `gain_pair01[17:9]`, 2 is `gain_pair23[8:0]`, 3 is `gain_pair23[17:9]`.
- R3: Outside off mode, `gain_idx[1]` is the line type (0 gives a 0,1,0,1 line, 1 gives a 2,3,2,3 line), and `gain_idx[0]` is a pixel phase that inverts on every clock unless a restart (R7) forces it to 0.
- R4: In progressive mode a VD falling edge sets the field number to 0 and the line type to 0, and each HD falling edge inverts the line type.
- R5: In interlaced mode each VD falling edge moves the field number to 1 if it was 0 and to 0 otherwise, the line type becomes 1 exactly when the new field number is 1, and HD falling edges leave the line type unchanged.
- R6: In three-field mode each VD falling edge steps the field number 0 to 1, 1 to 2, 2 to 0, the line type becomes 1 exactly when the new field number is 1, and each HD falling edge inverts the line type.
- R7: A sync level sampled low at clock edge k after a high sample at edge k-1 is a falling edge that updates the field number and line type at edge k+2; for HD the pixel phase is forced to 0 at edge k+9 (seven clocks after the line update), and a newer HD edge restarts that count.
- R8: A pulse on `field_wr` stores `field_next` (0 gives field 0, 1 gives field 1, 2 or 3 give field 2); in interlaced and three-field mode the next VD falling edge uses the stored value instead of stepping, and every VD falling edge discards a value stored before it.
- R9: In off mode `gain_idx` is 0 and `gain_word` is `gain_pair01[8:0]` on every pixel; a VD falling edge in off mode sets the field number and line type to 0.
- R10: When VD and HD falling edges are detected on the same clock, the VD rule applies and the HD edge does not invert the line type.
- R11: While `rst_n` is low and on the first clock after it, `gain_idx` is 0; reset leaves the field number 0, line type 0 and no stored next-field value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| vd_n | input | 1 | Active-low vertical sync, asynchronous to clk |
| hd_n | input | 1 | Active-low horizontal sync, asynchronous to clk |
| steer_mode | input | 2 | Readout mode: 0 off, 1 progressive, 2 interlaced, 3 three-field |
| field_next | input | 2 | Field number to force at the next field start |
| field_wr | input | 1 | One-clock strobe that stores `field_next` |
| gain_pair01 | input | 18 | Gain 0 in [8:0], gain 1 in [17:9] |
| gain_pair23 | input | 18 | Gain 2 in [8:0], gain 3 in [17:9] |
| gain_idx | output | 2 | Index of the gain applied to the current pixel |
| gain_word | output | 9 | The selected gain |

## Verification
The hardest situations to reach are the ones where two timing rules overlap: an HD edge landing before the seven-clock phase restart of the previous line has fired, and VD and HD edges detected on the same clock. The stimulus drives lines shorter than the restart delay and field starts with HD held low together with VD, as well as field starts with no coincident HD. The stored next-field value is written both well before and on the same clock a VD edge is detected, so that its consumption and carry-over are both exercised, while a behavioural model compares index and gain on every clock.

// File: rtl/csg_pkg.sv
package csg_pkg;

    typedef enum logic [1:0] {
        MODE_OFF   = 2'd0,
        MODE_PROG  = 2'd1,
        MODE_INTER = 2'd2,
        MODE_THREE = 2'd3
    } steer_mode_e;

    localparam int GAIN_W   = 9;
    localparam int NUM_GAIN = 4;
    localparam int IDX_W    = $clog2(NUM_GAIN);
    localparam int PAIR_W   = 2 * GAIN_W;
    localparam int FIELD_W  = 2;

    // Map a written next-field code to a field number (2 and 3 both mean field 2).
    function automatic logic [FIELD_W-1:0] map_field(input logic [FIELD_W-1:0] code);
        return (code >= FIELD_W'(2)) ? FIELD_W'(2) : code;
    endfunction

endpackage

// File: rtl/csg_sync_edge.sv
module csg_sync_edge #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_n,
    output logic fall
);

    typedef struct packed {
        logic [STAGES-1:0] chain;
        logic              prev;
    } sync_t;

    sync_t cur_q, nxt_d;
    logic  synced;

    assign synced = cur_q.chain[STAGES-1];

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.chain = {cur_q.chain[STAGES-2:0], sig_n};
        nxt_d.prev  = synced;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '1;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign fall = cur_q.prev & ~synced;

    AST_FALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        fall |=> !fall); // R7

endmodule

// File: rtl/csg_field_tracker.sv
module csg_field_tracker
    import csg_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  steer_mode_e        mode,
    input  logic               vd_fall,
    input  logic               hd_fall,
    input  logic               field_wr,
    input  logic [FIELD_W-1:0] field_next,
    output logic               line_type,
    output logic [FIELD_W-1:0] field_num
);

    typedef struct packed {
        logic [FIELD_W-1:0] field;
        logic               line;
        logic               armed;
        logic [FIELD_W-1:0] arm_val;
    } trk_t;

    trk_t cur_q, nxt_d;
    logic [FIELD_W-1:0] step_inter;
    logic [FIELD_W-1:0] step_three;
    logic [FIELD_W-1:0] new_field;

    always_comb begin
        step_inter = (cur_q.field == '0) ? FIELD_W'(1) : FIELD_W'(0);
        step_three = (cur_q.field == FIELD_W'(2)) ? FIELD_W'(0) : cur_q.field + FIELD_W'(1);
        new_field  = '0;

        nxt_d = cur_q;

        if (field_wr) begin
            nxt_d.armed   = 1'b1;
            nxt_d.arm_val = field_next;
        end else if (vd_fall) begin
            nxt_d.armed   = 1'b0;
        end

        if (vd_fall) begin
            unique case (mode)
                MODE_INTER: new_field = cur_q.armed ? map_field(cur_q.arm_val) : step_inter;
                MODE_THREE: new_field = cur_q.armed ? map_field(cur_q.arm_val) : step_three;
                default:    new_field = '0;
            endcase
            nxt_d.field = new_field;
            nxt_d.line  = (mode == MODE_INTER || mode == MODE_THREE) &&
                          (new_field == FIELD_W'(1));
        end else if (hd_fall && (mode == MODE_PROG || mode == MODE_THREE)) begin
            nxt_d.line = ~cur_q.line;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign line_type = cur_q.line;
    assign field_num = cur_q.field;

    AST_PROG_FIELD_START: assert property (@(posedge clk) disable iff (!rst_n)
        (vd_fall && mode == MODE_PROG) |=> (field_num == '0 && !line_type)); // R4

    AST_INTER_LINE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_INTER && !vd_fall) |=> $stable(line_type)); // R5

    AST_THREE_FIELD_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_THREE && vd_fall && !cur_q.armed) |=>
        (field_num == (($past(field_num) == FIELD_W'(2)) ? FIELD_W'(0) : $past(field_num) + FIELD_W'(1)))); // R6

    AST_FIELD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        field_num != FIELD_W'(3)); // R6

    AST_NEXT_FIELD_ARM: assert property (@(posedge clk) disable iff (!rst_n)
        field_wr |=> cur_q.armed); // R8

    AST_VD_OVER_HD: assert property (@(posedge clk) disable iff (!rst_n)
        (vd_fall && hd_fall && mode == MODE_THREE) |=> (line_type == (field_num == FIELD_W'(1)))); // R10

endmodule

// File: rtl/csg_pixel_phase.sv
module csg_pixel_phase #(
    parameter int HRST_DELAY = 7
) (
    input  logic clk,
    input  logic rst_n,
    input  logic hd_fall,
    output logic phase
);

    localparam int CNT_W = $clog2(HRST_DELAY + 1);

    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             phase;
    } ph_t;

    ph_t  cur_q, nxt_d;
    logic restart;

    assign restart = (cur_q.cnt == CNT_W'(1));

    always_comb begin
        nxt_d       = cur_q;
        nxt_d.phase = restart ? 1'b0 : ~cur_q.phase;
        if (hd_fall) begin
            nxt_d.cnt = CNT_W'(HRST_DELAY);
        end else if (cur_q.cnt != '0) begin
            nxt_d.cnt = cur_q.cnt - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign phase = cur_q.phase;

    AST_PHASE_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
        restart |=> !phase); // R7

    AST_PHASE_TOGGLE: assert property (@(posedge clk) disable iff (!rst_n)
        !restart |=> (phase != $past(phase))); // R3

endmodule

// File: rtl/csg_gain_select.sv
module csg_gain_select
    import csg_pkg::*;
(
    input  logic [IDX_W-1:0]  idx,
    input  logic [PAIR_W-1:0] pair01,
    input  logic [PAIR_W-1:0] pair23,
    output logic [GAIN_W-1:0] word
);

    localparam int NUM_PAIR = NUM_GAIN / 2;

    logic [PAIR_W-1:0] pairs [NUM_PAIR];
    logic [GAIN_W-1:0] gains [NUM_GAIN];

    assign pairs[0] = pair01;
    assign pairs[1] = pair23;

    for (genvar g = 0; g < NUM_GAIN; g++) begin : g_unpack
        assign gains[g] = pairs[g / 2][(g % 2) * GAIN_W +: GAIN_W];
    end

    assign word = gains[idx];

endmodule

// File: rtl/color_steer_top.sv
module color_steer_top
    import csg_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int HRST_DELAY  = 7
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vd_n,
    input  logic                hd_n,
    input  logic [1:0]          steer_mode,
    input  logic [FIELD_W-1:0]  field_next,
    input  logic                field_wr,
    input  logic [PAIR_W-1:0]   gain_pair01,
    input  logic [PAIR_W-1:0]   gain_pair23,
    output logic [IDX_W-1:0]    gain_idx,
    output logic [GAIN_W-1:0]   gain_word
);

    steer_mode_e        mode;
    logic               vd_fall;
    logic               hd_fall;
    logic               line_type;
    logic               phase;
    logic [FIELD_W-1:0] field_num;

    assign mode = steer_mode_e'(steer_mode);

    csg_sync_edge #(.STAGES(SYNC_STAGES)) u_vd_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .sig_n (vd_n),
        .fall  (vd_fall)
    );

    csg_sync_edge #(.STAGES(SYNC_STAGES)) u_hd_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .sig_n (hd_n),
        .fall  (hd_fall)
    );

    csg_field_tracker u_field (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode       (mode),
        .vd_fall    (vd_fall),
        .hd_fall    (hd_fall),
        .field_wr   (field_wr),
        .field_next (field_next),
        .line_type  (line_type),
        .field_num  (field_num)
    );

    csg_pixel_phase #(.HRST_DELAY(HRST_DELAY)) u_phase (
        .clk     (clk),
        .rst_n   (rst_n),
        .hd_fall (hd_fall),
        .phase   (phase)
    );

    assign gain_idx = (mode == MODE_OFF) ? '0 : {line_type, phase};

    csg_gain_select u_sel (
        .idx    (gain_idx),
        .pair01 (gain_pair01),
        .pair23 (gain_pair23),
        .word   (gain_word)
    );

    AST_OFF_FIRST_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (steer_mode == 2'd0) |-> (gain_idx == '0 && gain_word == gain_pair01[GAIN_W-1:0])); // R9

    AST_OFF_FIELD_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (vd_fall && steer_mode == 2'd0) |=> (field_num == '0 && !line_type)); // R9

    AST_PAIR_SELECT: assert property (@(posedge clk) disable iff (!rst_n)
        (gain_idx == 2'd3) |-> (gain_word == gain_pair23[PAIR_W-1:GAIN_W])); // R2

endmodule

// File: tb/color_steer_top_tb_top.sv
module color_steer_top_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        vd_n = 1'b1;
    logic        hd_n = 1'b1;
    logic [1:0]  steer_mode = 2'd1;
    logic [1:0]  field_next = 2'd0;
    logic        field_wr = 1'b0;
    logic [17:0] gain_pair01;
    logic [17:0] gain_pair23;
    logic [1:0]  gain_idx;
    logic [8:0]  gain_word;

    int    n_cmp = 0;
    int    n_bad = 0;
    string cur_req = "R11";
    bit    done = 1'b0;

    always #10 clk = ~clk;

    color_steer_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .vd_n        (vd_n),
        .hd_n        (hd_n),
        .steer_mode  (steer_mode),
        .field_next  (field_next),
        .field_wr    (field_wr),
        .gain_pair01 (gain_pair01),
        .gain_pair23 (gain_pair23),
        .gain_idx    (gain_idx),
        .gain_word   (gain_word)
    );

    // Behavioural reference: sample histories, edge counter, integer field state.
    int cyc = 0;
    int restart_at = -1;
    bit vh[$];
    bit hh[$];
    int m_field = 0;
    bit m_line = 0;
    bit m_phase = 0;
    bit m_armed = 0;
    int m_arm = 0;

    function automatic int code_to_field(int c);
        return (c >= 2) ? 2 : c;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cyc = 0; restart_at = -1;
            vh = '{1, 1, 1}; hh = '{1, 1, 1};
            m_field = 0; m_line = 0; m_phase = 0; m_armed = 0; m_arm = 0;
        end else begin
            bit vf, hf;
            int nf;
            bit old_armed;
            int old_arm;
            cyc++;
            vf = (vh[1] == 0) && (vh[2] == 1);
            hf = (hh[1] == 0) && (hh[2] == 1);
            old_armed = m_armed;
            old_arm = m_arm;
            // R3 / R7: phase inverts, forced low at the restart edge
            if (cyc == restart_at) m_phase = 0; else m_phase = ~m_phase;
            if (hf) restart_at = cyc + 7;
            // R8: one-shot next-field store
            if (field_wr) begin m_armed = 1; m_arm = field_next; end
            else if (vf) m_armed = 0;
            if (vf) begin
                case (steer_mode)
                    2'd2: nf = old_armed ? code_to_field(old_arm) : ((m_field == 0) ? 1 : 0);
                    2'd3: nf = old_armed ? code_to_field(old_arm) : ((m_field + 1) % 3);
                    default: nf = 0;
                endcase
                m_field = nf;
                m_line = (steer_mode >= 2) && (nf == 1);
            end else if (hf && (steer_mode == 2'd1 || steer_mode == 2'd3)) begin
                m_line = ~m_line;
            end
            void'(vh.pop_back()); vh.push_front(vd_n);
            void'(hh.pop_back()); hh.push_front(hd_n);
        end
    end

    function automatic logic [8:0] gain_of(int i);
        case (i)
            0: return gain_pair01[8:0];
            1: return gain_pair01[17:9];
            2: return gain_pair23[8:0];
            default: return gain_pair23[17:9];
        endcase
    endfunction

    always @(negedge clk) begin
        if (!done) begin
            int e_idx;
            e_idx = (!rst_n || steer_mode == 2'd0) ? 0 : {m_line, m_phase};
            n_cmp++;
            if (gain_idx !== 2'(e_idx)) begin
                n_bad++;
                $display("FAIL %s cyc=%0d gain_idx=%0d expected=%0d", cur_req, cyc, gain_idx, e_idx);
            end
            n_cmp++;
            if (gain_word !== gain_of(e_idx)) begin
                n_bad++;
                $display("FAIL R2 (%s) cyc=%0d gain_word=%0h expected=%0h", cur_req, cyc, gain_word, gain_of(e_idx));
            end
        end
    end

    task automatic tick(int n);
        repeat (n) begin @(posedge clk); #2; end
    endtask

    // One line: HD low for two clocks, optionally VD low with it for a field start.
    task automatic line(int len, bit with_vd);
        hd_n = 1'b0; vd_n = with_vd ? 1'b0 : 1'b1;
        tick(2);
        hd_n = 1'b1; vd_n = 1'b1;
        tick(len - 2);
    endtask

    task automatic field(int nlines, int len);
        line(len, 1'b1);
        for (int i = 1; i < nlines; i++) line(len, 1'b0);
    endtask

    task automatic vd_only(int len);
        vd_n = 1'b0; tick(2); vd_n = 1'b1; tick(len - 2);
    endtask

    task automatic write_next(int code);
        field_next = 2'(code); field_wr = 1'b1; tick(1); field_wr = 1'b0;
    endtask

    initial begin
        gain_pair01 = {9'h1A5, 9'h03C};
        gain_pair23 = {9'h0F0, 9'h155};
        cur_req = "R11"; // reset state, index 0 during and right after reset
        tick(5);
        rst_n = 1'b1;
        tick(3);
        cur_req = "R4"; // progressive, several lines per field, two fields
        steer_mode = 2'd1;
        field(5, 20);
        field(4, 13);
        cur_req = "R7"; // lines shorter than the restart delay
        field(4, 5);
        line(9, 1'b0);
        cur_req = "R10"; // VD and HD together, progressive
        field(3, 16);
        cur_req = "R5"; // interlaced fields, HD must not change pairs
        steer_mode = 2'd2;
        field(3, 14);
        field(3, 14);
        vd_only(12);
        line(12, 1'b0);
        cur_req = "R8"; // next-field write in interlaced mode
        write_next(1);
        field(2, 14);
        write_next(3);
        field(2, 14);
        field(2, 14);
        cur_req = "R6"; // three-field cycle
        steer_mode = 2'd3;
        for (int f = 0; f < 5; f++) field(4, 15);
        vd_only(10);
        line(10, 1'b0);
        cur_req = "R8"; // stored value overrides the step, then is consumed
        write_next(0);
        field(3, 15);
        field(3, 15);
        write_next(2);
        field(2, 15);
        cur_req = "R8"; // write on the clock the VD edge is detected
        vd_n = 1'b0; hd_n = 1'b0; tick(2); vd_n = 1'b1; hd_n = 1'b1;
        write_next(1);
        tick(12);
        field(2, 12);
        field(2, 12);
        cur_req = "R8"; // progressive ignores a stored value but consumes it
        steer_mode = 2'd1;
        write_next(1);
        field(2, 12);
        steer_mode = 2'd3;
        field(2, 12);
        cur_req = "R9"; // off mode
        steer_mode = 2'd0;
        field(3, 12);
        cur_req = "R1"; // mode switches mid-line
        steer_mode = 2'd1; tick(3);
        steer_mode = 2'd2; tick(3);
        steer_mode = 2'd3; tick(3);
        steer_mode = 2'd0; tick(3);
        steer_mode = 2'd3;
        cur_req = "R2"; // new gain values
        gain_pair01 = {9'h0FF, 9'h100};
        gain_pair23 = {9'h001, 9'h1FE};
        field(3, 10);
        cur_req = "R3";
        tick(20);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        done = 1'b1;
        n_bad++;
        $display("FAIL watchdog (%s) cycles=150000 expected=end of stimulus", cur_req);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule